// File: doc/BRIEF.md
# Dual-Bank FSK Phase Synthesizer Core

This block is the digital core of a direct digital synthesizer running from the reference clock. Two 22-bit frequency settings are held on its inputs. A select pin picks one of them as the carrier. When frequency-shift keying is enabled, a data pin adds a scaled 8-bit deviation to that carrier. The resulting tuning word is added on every clock into a 24-bit phase accumulator. The upper accumulator bits address a quarter-wave sine table, and the result is an 11-bit signed sample for an external converter.

The select pin and the data pin may come from another clock domain, so each is synchronized before it reaches the tuning word. An active-low standby input parks the accumulator at zero and drives the sample to mid-scale. The tuning inputs are unaffected by standby, so output resumes at once on the programmed frequency when standby is released.

Top module: `fsk_dds_core`

## Requirements
- R1: Each clock edge with standby high and reset low sets `phase_o` to the previous `phase_o` plus the tuning word, modulo 2^24.
- R2: The tuning word is the selected 22-bit setting with its two upper bits zero. `mode_i` = 0 selects `freq0_i` and `mode_i` = 1 selects `freq1_i`.
- R3: With `fsk_off_i` = 0 and `tx_data_i` = 1, the tuning word also carries `dev_i` in bits 9..2 (bits 1..0 zero), which adds 4×`dev_i`. With `tx_data_i` = 0, no deviation is added.
- R4: With `fsk_off_i` = 1, `tx_data_i` has no effect and the tuning word equals the selected setting.
- R5: With standby high, `sample_o` is an 11-bit two's-complement value equal to round(1023·sin(2π·(k+0.5)/1024)), where k is bits 23..14 of the `phase_o` value from two clocks earlier. Rounding is symmetric about zero, so the range is -1023..+1023.
- R6: A change on `mode_i` or `tx_data_i`, applied between edges, first alters the phase step on the fourth following clock edge. The first three steps keep the old value.
- R7: While `stby_n` is 0, `phase_o` is 0 from the next edge on, and `sample_o` is 0 from the edge after that.
- R8: When `stby_n` returns to 1, the first edge sets `phase_o` to the current tuning word. The frequency and deviation settings in force before standby still apply.
- R9: During and directly after synchronous reset, `phase_o` and `sample_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_n | input | 1 | Standby, active low |
| mode_i | input | 1 | Bank select (asynchronous) |
| tx_data_i | input | 1 | FSK data bit (asynchronous) |
| fsk_off_i | input | 1 | 1 disables the deviation path |
| freq0_i | input | 22 | Bank 0 frequency setting |
| freq1_i | input | 22 | Bank 1 frequency setting |
| dev_i | input | 8 | FSK deviation byte |
| phase_o | output | 24 | Phase accumulator value |
| sample_o | output | 11 | Signed sine sample |

## Verification
The bench mixes seeded random settings for both banks, the deviation, the bank select, the data bit and the FSK disable. In each case it measures the accumulator step, so that a wrong bank choice, a misplaced deviation field or a data bit that leaks through while FSK is disabled each gives a distinct wrong step. Directed cases use the largest settings with the largest deviation to exercise carry into the top bits and phase wrap. They also time a bank toggle against the synchronizer depth, and cover entry into and exit from standby. Throughout the run, every sample is compared with a sine computed from the phase two cycles earlier, which also exposes errors in quadrant mirroring and sign.

// File: rtl/fsk_dds_pkg.sv
package fsk_dds_pkg;
  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_RISE = 2'd2,
    QD_NEG_FALL = 2'd3
  } quad_e;
endpackage

// File: rtl/fsk_dds_sync.sv
module fsk_dds_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    if (STAGES == 2) begin : g_two
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (q_o[b] != $past(q_o[b])) |-> (q_o[b] == $past(d_i[b], 2))); // R6
    end
  end
endmodule

// File: rtl/fsk_dds_tuning.sv
module fsk_dds_tuning #(
  parameter int PHASE_W   = 24,
  parameter int FREQ_W    = 22,
  parameter int DEV_W     = 8,
  parameter int DEV_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_s,
  input  logic               tx_s,
  input  logic               fsk_off_i,
  input  logic [FREQ_W-1:0]  freq0_i,
  input  logic [FREQ_W-1:0]  freq1_i,
  input  logic [DEV_W-1:0]   dev_i,
  output logic [PHASE_W-1:0] tw_o
);
  localparam int PAD_W = PHASE_W - FREQ_W;

  logic [FREQ_W-1:0]  sel_freq;
  logic [PHASE_W-1:0] base_w;
  logic [PHASE_W-1:0] dev_w;
  logic               add_dev;

  always_comb begin
    sel_freq = mode_s ? freq1_i : freq0_i;
    base_w   = {{PAD_W{1'b0}}, sel_freq};
    dev_w    = PHASE_W'(dev_i) << DEV_SHIFT;
    add_dev  = !fsk_off_i && tx_s;
  end

  always_ff @(posedge clk) begin
    if (rst) tw_o <= '0;
    else     tw_o <= add_dev ? (base_w + dev_w) : base_w;
  end

  AST_FSK_OFF_BANK0: assert property (@(posedge clk) disable iff (rst)
    (fsk_off_i && !mode_s) |=> (tw_o == PHASE_W'($past(freq0_i)))); // R4
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!tx_s) |=> (tw_o[PHASE_W-1 -: PAD_W] == '0)); // R2
endmodule

// File: rtl/fsk_dds_accum.sv
module fsk_dds_accum #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stby_n,
  input  logic [PHASE_W-1:0] tw_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk) begin
    if (rst || !stby_n) phase_o <= '0;
    else                phase_o <= phase_o + tw_i;
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    stby_n |=> (phase_o == PHASE_W'($past(phase_o) + $past(tw_i)))); // R1
  AST_STBY_PHASE: assert property (@(posedge clk) disable iff (rst)
    !stby_n |=> (phase_o == '0)); // R7
endmodule

// File: rtl/fsk_dds_shaper.sv
module fsk_dds_shaper
  import fsk_dds_pkg::*;
#(
  parameter int PHASE_W  = 24,
  parameter int LUT_AW   = 8,
  parameter int SAMPLE_W = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stby_n,
  input  logic [PHASE_W-1:0]         phase_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam int    MAG_W     = SAMPLE_W - 1;
  localparam int    LUT_DEPTH = 1 << LUT_AW;
  localparam real   AMP       = real'((1 << MAG_W) - 1);
  localparam real   HALF_PI   = 1.5707963267948966;
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [MAG_W-1:0] lut [LUT_DEPTH];

  initial begin
    for (int i = 0; i < LUT_DEPTH; i++) begin
      real ang;
      ang    = HALF_PI * (real'(i) + 0.5) / real'(LUT_DEPTH);
      lut[i] = MAG_W'($rtoi(AMP * $sin(ang) + 0.5));
    end
  end

  quad_e             quad;
  logic [LUT_AW-1:0] raw_idx;
  logic [LUT_AW-1:0] idx;

  always_comb begin
    quad    = quad_e'(phase_i[PHASE_W-1 -: 2]);
    raw_idx = phase_i[PHASE_W-3 -: LUT_AW];
    idx     = (quad == QD_FALL || quad == QD_NEG_FALL) ? ~raw_idx : raw_idx;
  end

  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    mag_q <= lut[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      neg_q <= quad[1];
      act_q <= stby_n;
    end
  end

  logic signed [SAMPLE_W-1:0] mag_s;
  assign mag_s = $signed({1'b0, mag_q});

  always_ff @(posedge clk) begin
    if (rst || !act_q) sample_o <= '0;
    else if (neg_q)    sample_o <= -mag_s;
    else               sample_o <= mag_s;
  end

  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    sample_o != MOST_NEG); // R5
endmodule

// File: rtl/fsk_dds_core.sv
module fsk_dds_core #(
  parameter int PHASE_W   = 24,
  parameter int FREQ_W    = 22,
  parameter int DEV_W     = 8,
  parameter int DEV_SHIFT = 2,
  parameter int LUT_AW    = 8,
  parameter int SAMPLE_W  = 11,
  parameter int SYNC_STG  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stby_n,
  input  logic                       mode_i,
  input  logic                       tx_data_i,
  input  logic                       fsk_off_i,
  input  logic [FREQ_W-1:0]          freq0_i,
  input  logic [FREQ_W-1:0]          freq1_i,
  input  logic [DEV_W-1:0]           dev_i,
  output logic [PHASE_W-1:0]         phase_o,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  logic [1:0]         ctl_s;
  logic [PHASE_W-1:0] tw;

  fsk_dds_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({tx_data_i, mode_i}),
    .q_o (ctl_s)
  );

  fsk_dds_tuning #(
    .PHASE_W(PHASE_W), .FREQ_W(FREQ_W), .DEV_W(DEV_W), .DEV_SHIFT(DEV_SHIFT)
  ) u_tune (
    .clk       (clk),
    .rst       (rst),
    .mode_s    (ctl_s[0]),
    .tx_s      (ctl_s[1]),
    .fsk_off_i (fsk_off_i),
    .freq0_i   (freq0_i),
    .freq1_i   (freq1_i),
    .dev_i     (dev_i),
    .tw_o      (tw)
  );

  fsk_dds_accum #(.PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .stby_n  (stby_n),
    .tw_i    (tw),
    .phase_o (phase_o)
  );

  fsk_dds_shaper #(
    .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SAMPLE_W(SAMPLE_W)
  ) u_shape (
    .clk      (clk),
    .rst      (rst),
    .stby_n   (stby_n),
    .phase_i  (phase_o),
    .sample_o (sample_o)
  );

  AST_STBY_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!stby_n && !$past(stby_n)) |=> (sample_o == '0)); // R7
endmodule

// File: tb/fsk_dds_core_tb.sv
module fsk_dds_core_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               stby_n = 1'b0;
  logic               mode_i = 1'b0;
  logic               tx_data_i = 1'b0;
  logic               fsk_off_i = 1'b0;
  logic [21:0]        freq0_i = '0;
  logic [21:0]        freq1_i = '0;
  logic [7:0]         dev_i = '0;
  logic [23:0]        phase_o;
  logic signed [10:0] sample_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fsk_dds_core u_dut (
    .clk(clk), .rst(rst), .stby_n(stby_n), .mode_i(mode_i),
    .tx_data_i(tx_data_i), .fsk_off_i(fsk_off_i), .freq0_i(freq0_i),
    .freq1_i(freq1_i), .dev_i(dev_i), .phase_o(phase_o), .sample_o(sample_o)
  );

  function automatic logic [23:0] exp_step(logic [21:0] f0, logic [21:0] f1,
      logic [7:0] dv, logic md, logic tx, logic off);
    logic [23:0] s;
    s = md ? {2'b00, f1} : {2'b00, f0};
    if (!off && tx) s = s + {14'd0, dv, 2'b00};
    return s;
  endfunction

  function automatic int exp_sample(logic [23:0] p);
    real a, s;
    a = 6.283185307179586 * (real'(p[23:14]) + 0.5) / 1024.0;
    s = 1023.0 * $sin(a);
    if (s >= 0.0) return $rtoi(s + 0.5);
    return -$rtoi(-s + 0.5);
  endfunction

  task automatic report(string req, bit ok, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic observe();
    @(posedge clk); #5;
  endtask

  // R5 / R7: continuous sample check against phase two observations back
  logic [23:0] ph_h1, ph_h2;
  logic        sb_h1, rs_h1, rs_h2;
  int          obs = 0;
  always @(posedge clk) begin
    #5;
    if (obs >= 2 && !rst && !rs_h1 && !rs_h2) begin
      if (sb_h1) begin
        int e, d;
        e = exp_sample(ph_h2);
        d = int'(sample_o) - e;
        report("R5 sample", (d >= -1 && d <= 1), sample_o, e);
      end else begin
        report("R7 standby sample", sample_o == 0, sample_o, 0);
      end
    end
    ph_h2 = ph_h1; ph_h1 = phase_o;
    rs_h2 = rs_h1; rs_h1 = rst;
    sb_h1 = stby_n;
    obs++;
  end

  task automatic check_steps(logic [23:0] e, int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [23:0] p0;
      p0 = phase_o;
      observe();
      report(req, (phase_o - p0) == e, phase_o - p0, e);
    end
  endtask

  task automatic apply(logic [21:0] f0, logic [21:0] f1, logic [7:0] dv,
      logic md, logic tx, logic off);
    @(negedge clk);
    freq0_i = f0; freq1_i = f1; dev_i = dv;
    mode_i = md; tx_data_i = tx; fsk_off_i = off;
    repeat (5) observe();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) observe();
    // R9: reset state
    report("R9 reset phase", phase_o == 0, phase_o, 0);
    report("R9 reset sample", sample_o == 0, sample_o, 0);
    @(negedge clk); rst = 1'b0; stby_n = 1'b1;
    observe();
    report("R9 phase after reset", phase_o == 0, phase_o, 0);

    // R2: bank select, no deviation
    apply(22'h012345, 22'h2ABCDE, 8'h00, 1'b0, 1'b0, 1'b0);
    check_steps(24'h012345, 3, "R2 bank0 step");
    apply(22'h012345, 22'h2ABCDE, 8'h00, 1'b1, 1'b0, 1'b0);
    check_steps(24'h2ABCDE, 3, "R2 bank1 step");

    // R3: deviation field at bits 9..2, largest values with wrap (R1)
    apply(22'h3FFFFF, 22'h000100, 8'hFF, 1'b0, 1'b1, 1'b0);
    check_steps(24'h4003FB, 40, "R1 R3 max step with wrap");
    apply(22'h3FFFFF, 22'h000100, 8'hFF, 1'b0, 1'b0, 1'b0);
    check_steps(24'h3FFFFF, 3, "R3 data low no deviation");
    apply(22'h3FFFFF, 22'h000100, 8'h01, 1'b1, 1'b1, 1'b0);
    check_steps(24'h000104, 3, "R3 deviation of one");

    // R4: FSK disabled ignores data bit
    apply(22'h001000, 22'h0ABCDE, 8'hA5, 1'b1, 1'b1, 1'b1);
    check_steps(24'h0ABCDE, 3, "R4 data ignored");

    // R6: synchronizer latency on a bank toggle
    apply(22'h000400, 22'h020000, 8'h00, 1'b0, 1'b0, 1'b0);
    begin
      logic [23:0] p0;
      p0 = phase_o;
      @(negedge clk); mode_i = 1'b1;
      for (int k = 1; k <= 4; k++) begin
        logic [23:0] e;
        observe();
        e = (k < 4) ? 24'h000400 : 24'h020000;
        report("R6 sync latency", (phase_o - p0) == e, phase_o - p0, e);
        p0 = phase_o;
      end
    end

    // R7 / R8: standby entry and exit
    apply(22'h055555, 22'h011111, 8'h22, 1'b0, 1'b1, 1'b0);
    @(negedge clk); stby_n = 1'b0;
    repeat (3) observe();
    report("R7 standby phase", phase_o == 0, phase_o, 0);
    report("R7 standby sample", sample_o == 0, sample_o, 0);
    @(negedge clk); stby_n = 1'b1;
    observe();
    report("R8 restart phase", phase_o == 24'h055555 + 24'd136, phase_o, 24'h055555 + 24'd136);
    check_steps(24'h055555 + 24'd136, 3, "R8 settings kept");

    // Random mix: R1 R2 R3 R4 R5
    for (int t = 0; t < 120; t++) begin
      logic [21:0] f0, f1;
      logic [7:0]  dv;
      logic        md, tx, off;
      f0 = 22'($urandom); f1 = 22'($urandom); dv = 8'($urandom);
      md = 1'($urandom); tx = 1'($urandom); off = 1'($urandom);
      apply(f0, f1, dv, md, tx, off);
      check_steps(exp_step(f0, f1, dv, md, tx, off), 4, "R1 R2 R3 R4 random step");
    end

    observe();
    finish_run();
  end
endmodule